// File: doc/BRIEF.md
# Bidirectional Tapped Delay Chain Selector

This block feeds a delay estimator that works on two one-bit quantized sensor streams, A and B. It keeps the recent history of each stream in its own shift-register delay line. On each sample-enable pulse, both lines advance by one position. A signed tap index then selects two bits for the estimator: a base bit and a tap bit.

The base bit is always the newest sample of one line. The tap bit is an older sample taken from the other line. The sign of the index decides which line is swept:
- A zero or positive index means A is taken as leading. The base is the newest B sample, and the index value picks the A tap.
- A negative index means B leads. The base is the newest A sample, and the B line is swept.

One magnitude decoder serves both directions. The B line's select inputs are wired in reverse order, so the decoder uses only the low index bits. The cost of this is a fixed offset of one tap less on the negative side, which is left for software to correct. Both selected bits are registered before they leave the block.

Top module: `tap_pair_selector`

## Requirements
- R1: A synchronous active-low reset clears every tap of both lines and both outputs to 0.
- R2: The lines shift only in a cycle where `sample_en` is 1. When a line shifts, the new input enters tap 0 and each tap k takes the old value of tap k-1. When `sample_en` is 0, all taps hold their values.
- R3: For an index v with 0 <= v, the next `base_bit` equals B tap 0 and the next `tap_bit` equals A tap v.
- R4: For an index v = -k with k >= 1, the next `base_bit` equals A tap 0 and the next `tap_bit` equals B tap k-1, which is a fixed one-tap offset.
- R5: The most negative index, -2^(IDX_W-1), selects B tap 2^(IDX_W-1)-1. The most positive index selects A tap 2^(IDX_W-1)-1.
- R6: The outputs are registered. The values seen after a clock edge come from the tap state and the index that were present just before that edge.
- R7: Each line holds 2^(IDX_W-1) taps. A sample that is shifted past the last tap is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | One-cycle strobe that advances both lines |
| sig_a | input | 1 | Quantized stream A |
| sig_b | input | 1 | Quantized stream B |
| tap_idx | input | IDX_W | Signed two's-complement tap index; the MSB selects the direction |
| base_bit | output | 1 | Registered newest sample of the line that is not swept |
| tap_bit | output | 1 | Registered selected tap of the swept line |

## Verification
The bench builds the block with IDX_W = 6, which gives 32 taps per line. At that size, every index from -32 to +31 can be swept in a short run. Overrunning both lines, so that old samples are shown to drop off the end, also becomes cheap. It also means both extreme indices, and the one-tap offset at every negative index, are checked against a behavioural model that keeps each stream's history in a queue. Sample-enable gaps and a reset applied to lines that were previously filled with ones exercise the hold and clear behaviour.

// File: rtl/tapsel_pkg.sv
// Package: shared types for the tap pair selector.
// Assumes the MSB of the tap index is the two's-complement sign.
package tapsel_pkg;
    // Which line is swept for the tap bit (the value is the index sign)
    typedef enum logic {
        SWEEP_A = 1'b0,
        SWEEP_B = 1'b1
    } sweep_role_e;
endpackage

// File: rtl/sipo_chain.sv
// Module: serial-in parallel-out delay line.
// On shift_en, din enters tap 0 and every older tap moves up by one.
// Assumes DEPTH >= 2. The reset is synchronous and active low.
module sipo_chain #(
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    // Shift register: clear on reset, advance on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            taps <= '0;
        else if (shift_en)
            taps <= {taps[DEPTH-2:0], din};
    end

    // R2: taps hold when there is no strobe
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && $past(rst_n)) |=> $stable(taps));

    // R2: the new sample lands in tap 0 and the older taps move up by one
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (taps[0] == $past(din)) &&
                     (taps[DEPTH-1:1] == $past(taps[DEPTH-2:0])));
endmodule

// File: rtl/mag_decoder.sv
// Module: one-hot decoder of the tap magnitude.
// Both delay lines share this single decoder.
// Assumes DEPTH == 2**SEL_W, so that every code selects a tap.
module mag_decoder #(
    parameter int SEL_W = 7,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] mag,
    output logic [DEPTH-1:0] sel_oh
);
    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_line
            // One select line for each code value
            assign sel_oh[i] = (mag == SEL_W'(i));
        end
    endgenerate

    // R3: exactly one select line is active for any magnitude
    always_comb begin
        a_r3_single_select: assert ($countones(sel_oh) == 1 || $isunknown(mag));
    end
endmodule

// File: rtl/tap_mux.sv
// Module: AND-OR tap multiplexer driven by one-hot select lines.
// REVERSE = 1 connects select line i to tap DEPTH-1-i. This lets one decoder
// serve a line that is swept from the far end.
module tap_mux #(
    parameter int DEPTH   = 128,
    parameter bit REVERSE = 1'b0
) (
    input  logic [DEPTH-1:0] taps,
    input  logic [DEPTH-1:0] sel_oh,
    output logic             bit_out
);
    logic [DEPTH-1:0] wired_sel;

    genvar i;
    generate
        if (REVERSE) begin : g_rev
            for (i = 0; i < DEPTH; i++) begin : g_w
                // Reversed wiring of the select lines
                assign wired_sel[i] = sel_oh[DEPTH-1-i];
            end
        end else begin : g_fwd
            // Straight wiring of the select lines
            assign wired_sel = sel_oh;
        end
    endgenerate

    // OR-reduce the taps that are enabled
    assign bit_out = |(taps & wired_sel);
endmodule

// File: rtl/tap_pair_selector.sv
// Module: top of the bidirectional tapped delay chain selector.
// Two delay lines, one shared magnitude decoder, a straight mux on line A,
// a reversed mux on line B, and registered outputs.
// Assumes sample_en is a one-cycle strobe derived from clk.
// A negative index reads one tap nearer than its magnitude, and nothing here
// corrects that.
module tap_pair_selector
    import tapsel_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             sig_a,
    input  logic             sig_b,
    input  logic [IDX_W-1:0] tap_idx,
    output logic             base_bit,
    output logic             tap_bit
);
    localparam int SEL_W = IDX_W - 1;
    localparam int TAPS  = 1 << SEL_W;

    logic [TAPS-1:0]  a_taps, b_taps, sel_oh;
    logic [SEL_W-1:0] mag;
    logic             a_pick, b_pick;
    sweep_role_e      role;

    assign mag  = tap_idx[SEL_W-1:0];
    assign role = sweep_role_e'(tap_idx[IDX_W-1]);

    sipo_chain #(.DEPTH(TAPS)) u_line_a (
        .clk(clk), .rst_n(rst_n), .shift_en(sample_en), .din(sig_a), .taps(a_taps));
    sipo_chain #(.DEPTH(TAPS)) u_line_b (
        .clk(clk), .rst_n(rst_n), .shift_en(sample_en), .din(sig_b), .taps(b_taps));

    mag_decoder #(.SEL_W(SEL_W)) u_dec (.mag(mag), .sel_oh(sel_oh));

    tap_mux #(.DEPTH(TAPS), .REVERSE(1'b0)) u_mux_a (
        .taps(a_taps), .sel_oh(sel_oh), .bit_out(a_pick));
    tap_mux #(.DEPTH(TAPS), .REVERSE(1'b1)) u_mux_b (
        .taps(b_taps), .sel_oh(sel_oh), .bit_out(b_pick));

    // Output register: the role decides which line gives the base and the tap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_bit <= 1'b0;
            tap_bit  <= 1'b0;
        end else if (role == SWEEP_B) begin
            base_bit <= a_taps[0];
            tap_bit  <= b_pick;
        end else begin
            base_bit <= b_taps[0];
            tap_bit  <= a_pick;
        end
    end

    // R1: reset clears both outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!base_bit && !tap_bit));

    // R3 / R6: a non-negative index reads A at the index value
    a_r3_positive_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tap_idx[IDX_W-1]) |=>
            (base_bit == $past(b_taps[0])) && (tap_bit == $past(a_taps[mag])));

    // R4 / R6: a negative index -k reads B tap k-1 (that is, tap ~index)
    a_r4_negative_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tap_idx[IDX_W-1]) |=>
            (base_bit == $past(a_taps[0])) &&
            (tap_bit == $past(b_taps[SEL_W'(~tap_idx)])));

    // R5: the most negative index reaches the oldest tap of B
    a_r5_far_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tap_idx == {1'b1, {SEL_W{1'b0}}}) |=>
            (tap_bit == $past(b_taps[TAPS-1])));
endmodule

// File: tb/sim_tap_pair_selector.sv
// Bench: behavioural queue model, compared with the design on every clock.
module sim_tap_pair_selector;
    localparam int IDX_W = 6;
    localparam int TAPS  = 1 << (IDX_W - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0, sample_en = 1'b0, sig_a = 1'b0, sig_b = 1'b0;
    logic [IDX_W-1:0] tap_idx = '0;
    logic base_bit, tap_bit;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    int qa[$], qb[$];
    logic exp_base = 1'b0, exp_tap = 1'b0;
    bit have_exp = 1'b0;
    string exp_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    tap_pair_selector #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sig_a(sig_a),
        .sig_b(sig_b), .tap_idx(tap_idx), .base_bit(base_bit), .tap_bit(tap_bit));

    function automatic logic qget(ref int q[$], input int i);
        return (i < q.size()) ? logic'(q[i]) : 1'b0;
    endfunction

    function automatic string tag_for(input int v);
        if (v == -TAPS || v == TAPS - 1) return "R5";
        if (v < 0) return "R4";
        return "R3";
    endfunction

    task automatic rnd_bits(output logic x, output logic y);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        x = lfsr[0];
        y = lfsr[5];
    endtask

    // One cycle: check the previous expectation, drive, predict, then clock
    task automatic step(input logic r, input logic s, input logic a, input logic b,
                        input int v, input string tag);
        if (have_exp) begin
            checks++;
            if (base_bit !== exp_base || tap_bit !== exp_tap) begin
                errors++;
                $display("FAIL %s: base/tap=%b%b expected %b%b", exp_tag,
                         base_bit, tap_bit, exp_base, exp_tap);
            end
        end
        rst_n = r; sample_en = s; sig_a = a; sig_b = b;
        tap_idx = IDX_W'(v);
        if (!r) begin
            exp_base = 1'b0; exp_tap = 1'b0;
            qa.delete(); qb.delete();
        end else begin
            if (v < 0) begin
                exp_base = qget(qa, 0); exp_tap = qget(qb, -v - 1);
            end else begin
                exp_base = qget(qb, 0); exp_tap = qget(qa, v);
            end
            if (s) begin
                qa.push_front(int'(a)); qb.push_front(int'(b));
                if (qa.size() > TAPS) void'(qa.pop_back());   // R7
                if (qb.size() > TAPS) void'(qb.pop_back());
            end
        end
        have_exp = 1'b1;
        exp_tag = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic x, y;
        @(negedge clk);
        // Fill with ones before the reset so that the clear is visible (R1)
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, "R1");
        for (int i = 0; i < TAPS + 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 0, "R1");
        for (int v = -TAPS; v < TAPS; v++) step(1'b1, 1'b0, 1'b1, 1'b1, v, "R1");
        // Sparse strobes with a walking index: shifting and holding (R2, R6)
        for (int i = 0; i < 4 * TAPS; i++) begin
            rnd_bits(x, y);
            step(1'b1, (i % 4) == 0, x, y, (i % (2 * TAPS)) - TAPS, "R2");
        end
        // Dense random streams with the full index sweep (R3, R4, R5, R6)
        for (int i = 0; i < 6 * TAPS; i++) begin
            int v;
            rnd_bits(x, y);
            v = ((i * 7) % (2 * TAPS)) - TAPS;
            step(1'b1, 1'b1, x, y, v, tag_for(v));
        end
        // A single 1 per line pushed past the last tap (R7, R5)
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R7");
        for (int i = 0; i < TAPS - 2; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 0, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, TAPS - 1, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, -TAPS, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b0, -TAPS, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b0, TAPS - 1, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, -TAPS, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, TAPS - 1, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R6");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule